// File: doc/BRIEF.md
# DMA Channel Guard

This block holds the software-visible control state of a single DMA channel and keeps it safe while the channel is moving data. Software reaches it over a plain register bus: an address, write data, a write strobe and combinational read data. A separate transfer engine does the actual copying. The block gives that engine a one-cycle start pulse and watches it through three inputs: an end-of-block strobe, an access qualifier, and the address and direction of each access.

While the channel is busy, only a small set of registers and control bits accepts writes. Every other write is dropped silently. The block flags illegal engine accesses to the non-volatile memory window. It also flags a software disable that lands in the middle of a transfer. On either error it aborts the engine and drops the channel out of busy. It keeps a completion flag and an error flag, and each flag drives its own interrupt line. Channel reset and controller reset are honoured only when the matching enable bit is already clear.

The register bus is a control path, not a data stream, so it has no valid/ready handshake: a write takes effect at the clock edge on which the strobe is high, and read data follows the address in the same cycle.

Top module: `dma_chan_guard`

## Requirements
- R1: After reset, every register reads zero, and `chan_busy`, `eng_start`, `eng_abort`, `irq_cmp` and `irq_err` are low.
- R2: A write to CHCTL (0x1) with bit0 (enable) and bit2 (request) both set starts the channel when CTRL (0x0) bit0 is 1 and the channel is idle. `chan_busy` rises on the next cycle, CHCTL bit7 reads busy, and `eng_start` pulses for one cycle. If CTRL bit0 is 0, nothing starts.
- R3: While busy, an engine write to an address in [`NV_BASE`, `NV_BASE+NV_SIZE`) (default 0x1000..0x13FF) raises the error flag (FLAGS (0x3) bit1) on the next cycle. The same edge clears busy and the enable bit, and `eng_abort` pulses. Writes just outside the window do nothing.
- R4: While busy, an engine read of that window raises the same error only when `nv_sleep` is high.
- R5: While busy, a bus write of 0 to CHCTL bit0 or to CTRL bit0 raises the error flag and ends the transfer.
- R6: A write with CHCTL bit1 set clears every channel register, including both flags, when the enable bit is already 0. Otherwise the reset bit is ignored and the write's other bits apply.
- R7: A write with CTRL bit1 set clears all registers when CTRL bit0 is already 0. Otherwise it is ignored.
- R8: While busy, the following writes take effect: CTRL, FLAGS, TRIG (0x2), SCR0 (0x5), SCR1 (0x6), and CHCTL bits 3:0. Writes to LEVEL (0x4), SRCA (0x7) and CHCTL bits 6:4 are dropped.
- R9: With CHCTL bit3 (repeat) at 0, an end-of-block strobe sets the completion flag (FLAGS bit0) and clears busy. The enable bit stays set.
- R10: With repeat at 1, every end-of-block strobe sets the completion flag and busy stays high.
- R11: Writing 1 to a FLAGS bit clears that flag. A hardware set in the same cycle wins.
- R12: `irq_cmp` is the completion flag ANDed with a nonzero LEVEL[1:0]. `irq_err` is the error flag ANDed with a nonzero LEVEL[3:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| eng_blk_done | input | 1 | Engine finished a block |
| eng_acc_valid | input | 1 | Engine access this cycle |
| eng_acc_wr | input | 1 | Access is a write |
| eng_acc_addr | input | EAW (16) | Access address |
| nv_sleep | input | 1 | Non-volatile memory powered down |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_abort | output | 1 | One-cycle abort pulse after an error |
| chan_busy | output | 1 | Channel transfer in progress |
| irq_cmp | output | 1 | Completion interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
The assertions check several invariants on every cycle:
- busy never stands without the enable bit;
- an error always drops busy and enable on the next cycle;
- the abort pulse never overlaps busy;
- a non-repeating block end ends busy;
- a hardware flag set is never lost to a same-cycle clear;
- the locked registers stay unchanged across busy cycles.

Only the bench's scenarios can show the rest. That covers the exact window boundaries, the sleep qualification of reads, and reset being ignored or honoured depending on the enable bit. It also covers which CHCTL bits a busy write actually changes, and the repeat versus single completion sequence seen through FLAGS.

// File: rtl/dma_guard_pkg.sv
package dma_guard_pkg;
  localparam int DW  = 8;
  localparam int RAW = 4;

  localparam logic [RAW-1:0] A_CTRL  = 4'h0;
  localparam logic [RAW-1:0] A_CHCTL = 4'h1;
  localparam logic [RAW-1:0] A_TRIG  = 4'h2;
  localparam logic [RAW-1:0] A_FLAGS = 4'h3;
  localparam logic [RAW-1:0] A_LEVEL = 4'h4;
  localparam logic [RAW-1:0] A_SCR0  = 4'h5;
  localparam logic [RAW-1:0] A_SCR1  = 4'h6;
  localparam logic [RAW-1:0] A_SRCA  = 4'h7;

  // bit positions inside CTRL and CHCTL
  localparam int B_EN   = 0;
  localparam int B_RST  = 1;
  localparam int B_REQ  = 2;
  localparam int B_RPT  = 3;
  localparam int B_MODE = 4;  // three locked mode bits 6:4
  localparam int B_BUSY = 7;

  localparam int NFLAG = 2;   // index 0 completion, 1 error
  localparam int LVLW  = 2;
endpackage

// File: rtl/dma_guard_regs.sv
module dma_guard_regs
  import dma_guard_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [RAW-1:0]       addr,
  input  logic [DW-1:0]        wdata,
  input  logic                 err_now,
  input  logic                 blk_done,
  output logic                 ctrl_en,
  output logic                 ch_en,
  output logic                 busy,
  output logic                 rpt,
  output logic [2:0]           mode,
  output logic [DW-1:0]        trig,
  output logic [DW-1:0]        scr0,
  output logic [DW-1:0]        scr1,
  output logic [DW-1:0]        srca,
  output logic [NFLAG*LVLW-1:0] lvl,
  output logic                 chan_clr,
  output logic                 eng_start
);
  logic wr_ctrl, wr_chctl, ctrl_rst_ok, ch_rst_ok, start_ok;

  assign wr_ctrl     = we && (addr == A_CTRL);
  assign wr_chctl    = we && (addr == A_CHCTL);
  assign ctrl_rst_ok = wr_ctrl && wdata[B_RST] && !ctrl_en;
  assign ch_rst_ok   = wr_chctl && wdata[B_RST] && !ch_en;
  assign chan_clr    = ctrl_rst_ok || ch_rst_ok;
  assign start_ok    = wr_chctl && wdata[B_EN] && wdata[B_REQ] && ctrl_en
                       && !busy && !err_now && !ch_rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en   <= 1'b0;
      ch_en     <= 1'b0;
      busy      <= 1'b0;
      rpt       <= 1'b0;
      mode      <= '0;
      trig      <= '0;
      scr0      <= '0;
      scr1      <= '0;
      srca      <= '0;
      lvl       <= '0;
      eng_start <= 1'b0;
    end else begin
      eng_start <= start_ok;
      if (wr_ctrl && !ctrl_rst_ok) ctrl_en <= wdata[B_EN];
      if (chan_clr) begin
        ch_en <= 1'b0;
        busy  <= 1'b0;
        rpt   <= 1'b0;
        mode  <= '0;
        trig  <= '0;
        scr0  <= '0;
        scr1  <= '0;
        srca  <= '0;
        lvl   <= '0;
      end else begin
        if (wr_chctl) begin
          ch_en <= wdata[B_EN];
          rpt   <= wdata[B_RPT];
          if (!busy) mode <= wdata[B_MODE +: 3];
        end
        if (we && addr == A_TRIG) trig <= wdata;
        if (we && addr == A_SCR0) scr0 <= wdata;
        if (we && addr == A_SCR1) scr1 <= wdata;
        if (!busy && we && addr == A_LEVEL) lvl <= wdata[NFLAG*LVLW-1:0];
        if (!busy && we && addr == A_SRCA)  srca <= wdata;
        if (start_ok)                  busy <= 1'b1;
        else if (err_now)              busy <= 1'b0;
        else if (busy && blk_done && !rpt) busy <= 1'b0;
        if (err_now) ch_en <= 1'b0;
      end
    end
  end

  assert_busy_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ch_en && ctrl_en));

  assert_err_stops_channel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_now |=> (!busy && !ch_en));

  assert_single_block_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && blk_done && !rpt) |=> !busy);

  assert_locked_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(lvl) && $stable(srca) && $stable(mode)));
endmodule

// File: rtl/dma_guard_err.sv
module dma_guard_err #(
  parameter int              EAW     = 16,
  parameter logic [EAW-1:0]  NV_BASE = 16'h1000,
  parameter int              NV_SIZE = 1024
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           busy,
  input  logic           dis_write,
  input  logic           acc_valid,
  input  logic           acc_wr,
  input  logic [EAW-1:0] acc_addr,
  input  logic           nv_sleep,
  output logic           err_now,
  output logic           eng_abort
);
  localparam logic [EAW:0] WIN_LO = {1'b0, NV_BASE};
  localparam logic [EAW:0] WIN_HI = WIN_LO + (EAW+1)'(NV_SIZE);

  logic in_win, nv_wr_err, nv_rd_err;

  assign in_win    = ({1'b0, acc_addr} >= WIN_LO) && ({1'b0, acc_addr} < WIN_HI);
  assign nv_wr_err = acc_valid && acc_wr && in_win;
  assign nv_rd_err = acc_valid && !acc_wr && in_win && nv_sleep;
  assign err_now   = busy && (nv_wr_err || nv_rd_err || dis_write);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eng_abort <= 1'b0;
    else        eng_abort <= err_now;
  end

  assert_abort_after_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort |-> !busy);

  assert_awake_read_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!nv_sleep && !dis_write && !(acc_valid && acc_wr)) |-> !err_now);
endmodule

// File: rtl/dma_guard_flags.sv
module dma_guard_flags
  import dma_guard_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NFLAG-1:0]        set,
  input  logic                    clr_we,
  input  logic [NFLAG-1:0]        clr_mask,
  input  logic                    chan_clr,
  input  logic [NFLAG*LVLW-1:0]   lvl,
  output logic [NFLAG-1:0]        flag,
  output logic [NFLAG-1:0]        irq
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag[i] <= 1'b0;
      else if (chan_clr) flag[i] <= 1'b0;
      else               flag[i] <= set[i] | (flag[i] & ~(clr_we & clr_mask[i]));
    end
    assign irq[i] = flag[i] & (|lvl[i*LVLW +: LVLW]);

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (set[i] && !chan_clr) |=> flag[i]);
  end
endmodule

// File: rtl/dma_chan_guard.sv
module dma_chan_guard
  import dma_guard_pkg::*;
#(
  parameter int              EAW     = 16,
  parameter logic [EAW-1:0]  NV_BASE = 16'h1000,
  parameter int              NV_SIZE = 1024
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RAW-1:0]  bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            bus_we,
  output logic [DW-1:0]   bus_rdata,
  input  logic            eng_blk_done,
  input  logic            eng_acc_valid,
  input  logic            eng_acc_wr,
  input  logic [EAW-1:0]  eng_acc_addr,
  input  logic            nv_sleep,
  output logic            eng_start,
  output logic            eng_abort,
  output logic            chan_busy,
  output logic            irq_cmp,
  output logic            irq_err
);
  logic ctrl_en, ch_en, busy, rpt, chan_clr, err_now, dis_write;
  logic [2:0] mode;
  logic [DW-1:0] trig, scr0, scr1, srca;
  logic [NFLAG*LVLW-1:0] lvl;
  logic [NFLAG-1:0] flag, irq, set;

  assign dis_write = bus_we && !bus_wdata[B_EN]
                     && (bus_addr == A_CHCTL || bus_addr == A_CTRL);

  dma_guard_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .err_now(err_now), .blk_done(eng_blk_done),
    .ctrl_en(ctrl_en), .ch_en(ch_en), .busy(busy), .rpt(rpt), .mode(mode),
    .trig(trig), .scr0(scr0), .scr1(scr1), .srca(srca), .lvl(lvl),
    .chan_clr(chan_clr), .eng_start(eng_start)
  );

  dma_guard_err #(.EAW(EAW), .NV_BASE(NV_BASE), .NV_SIZE(NV_SIZE)) u_err (
    .clk(clk), .rst_n(rst_n), .busy(busy), .dis_write(dis_write),
    .acc_valid(eng_acc_valid), .acc_wr(eng_acc_wr), .acc_addr(eng_acc_addr),
    .nv_sleep(nv_sleep), .err_now(err_now), .eng_abort(eng_abort)
  );

  assign set[0] = busy && eng_blk_done && !err_now;
  assign set[1] = err_now;

  dma_guard_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set(set),
    .clr_we(bus_we && bus_addr == A_FLAGS), .clr_mask(bus_wdata[NFLAG-1:0]),
    .chan_clr(chan_clr), .lvl(lvl), .flag(flag), .irq(irq)
  );

  assign chan_busy = busy;
  assign irq_cmp   = irq[0];
  assign irq_err   = irq[1];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata[B_EN] = ctrl_en;
      A_CHCTL: begin
        bus_rdata[B_EN]         = ch_en;
        bus_rdata[B_RPT]        = rpt;
        bus_rdata[B_MODE +: 3]  = mode;
        bus_rdata[B_BUSY]       = busy;
      end
      A_TRIG:  bus_rdata = trig;
      A_FLAGS: bus_rdata[NFLAG-1:0] = flag;
      A_LEVEL: bus_rdata[NFLAG*LVLW-1:0] = lvl;
      A_SCR0:  bus_rdata = scr0;
      A_SCR1:  bus_rdata = scr1;
      A_SRCA:  bus_rdata = srca;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: tb/test_dma_chan_guard.sv
`timescale 1ns/1ps
module test_dma_chan_guard;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic eng_blk_done = 1'b0, eng_acc_valid = 1'b0, eng_acc_wr = 1'b0, nv_sleep = 1'b0;
  logic [15:0] eng_acc_addr = '0;
  logic eng_start, eng_abort, chan_busy, irq_cmp, irq_err;

  int total = 0, bad = 0;
  bit finished = 0;

  typedef struct {
    int         sel;   // 0 rdata, 1 busy, 2 irq_cmp, 3 irq_err, 4 abort, 5 start
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  dma_chan_guard i_dma_chan_guard (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .eng_blk_done(eng_blk_done),
    .eng_acc_valid(eng_acc_valid), .eng_acc_wr(eng_acc_wr),
    .eng_acc_addr(eng_acc_addr), .nv_sleep(nv_sleep), .eng_start(eng_start),
    .eng_abort(eng_abort), .chan_busy(chan_busy), .irq_cmp(irq_cmp), .irq_err(irq_err)
  );

  always #4 clk = ~clk;

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    if (sb.size() != 0) begin
      item_t it;
      logic [7:0] act;
      it = sb.pop_front();
      case (it.sel)
        0: act = bus_rdata;
        1: act = {7'd0, chan_busy};
        2: act = {7'd0, irq_cmp};
        3: act = {7'd0, irq_err};
        4: act = {7'd0, eng_abort};
        default: act = {7'd0, eng_start};
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input bit done = 0);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; eng_blk_done = done;
    @(posedge clk); #1;
    bus_we = 1'b0; eng_blk_done = 1'b0;
  endtask

  task automatic blk_done();
    @(posedge clk); #1;
    eng_blk_done = 1'b1;
    @(posedge clk); #1;
    eng_blk_done = 1'b0;
  endtask

  task automatic acc(input bit w, input logic [15:0] a);
    @(posedge clk); #1;
    eng_acc_valid = 1'b1; eng_acc_wr = w; eng_acc_addr = a;
    @(posedge clk); #1;
    eng_acc_valid = 1'b0;
  endtask

  // driver side of the scoreboard: push expectation, hold address through compare
  task automatic expect_val(input int sel, input logic [3:0] a, input logic [7:0] e, input string tag);
    item_t it;
    bus_addr = a;
    it.sel = sel; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    expect_val(0, a, e, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(4'h0, 8'h00, "R1 CTRL");
    rd(4'h1, 8'h00, "R1 CHCTL");
    rd(4'h3, 8'h00, "R1 FLAGS");
    expect_val(1, 4'h0, 0, "R1 busy");
    expect_val(3, 4'h0, 0, "R1 irq_err");

    // setup
    wr(4'h4, 8'h05);
    wr(4'h7, 8'h3C);
    wr(4'h1, 8'h60);
    rd(4'h1, 8'h60, "R8 idle mode write");
    wr(4'h0, 8'h01);

    // R2 start
    wr(4'h1, 8'h65);
    expect_val(5, 4'h1, 1, "R2 start pulse");
    rd(4'h1, 8'hE1, "R2 busy read");
    expect_val(5, 4'h1, 0, "R2 start one cycle");

    // R8 protection while busy
    wr(4'h4, 8'h0F);
    wr(4'h7, 8'hAA);
    wr(4'h1, 8'h0D);
    wr(4'h2, 8'h17);
    wr(4'h5, 8'h5A);
    rd(4'h4, 8'h05, "R8 LEVEL locked");
    rd(4'h7, 8'h3C, "R8 SRCA locked");
    rd(4'h1, 8'hE9, "R8 CHCTL partial");
    rd(4'h2, 8'h17, "R8 TRIG open");
    rd(4'h5, 8'h5A, "R8 SCR0 open");

    // R10 repeat completion
    blk_done();
    rd(4'h3, 8'h01, "R10 flag first");
    expect_val(1, 4'h0, 1, "R10 still busy");
    expect_val(2, 4'h0, 1, "R12 irq_cmp on");
    wr(4'h3, 8'h01);
    rd(4'h3, 8'h00, "R11 w1c");
    blk_done();
    rd(4'h3, 8'h01, "R10 flag again");

    // R11 set beats clear
    wr(4'h3, 8'h01, 1);
    rd(4'h3, 8'h01, "R11 set priority");

    // R9 single block
    wr(4'h1, 8'h05);
    wr(4'h3, 8'h01);
    rd(4'h1, 8'hE1, "R9 repeat off");
    blk_done();
    rd(4'h3, 8'h01, "R9 flag");
    expect_val(1, 4'h0, 0, "R9 busy cleared");
    rd(4'h1, 8'h61, "R9 enable kept");

    // R12 level gating
    wr(4'h4, 8'h04);
    expect_val(2, 4'h0, 0, "R12 irq_cmp gated");
    wr(4'h4, 8'h05);
    expect_val(2, 4'h0, 1, "R12 irq_cmp enabled");

    // R3 window writes
    wr(4'h3, 8'h01);
    wr(4'h1, 8'h65);
    acc(1, 16'h1200);
    expect_val(4, 4'h0, 1, "R3 abort pulse");
    rd(4'h3, 8'h02, "R3 error flag");
    expect_val(1, 4'h0, 0, "R3 busy dropped");
    rd(4'h1, 8'h60, "R3 enable dropped");
    expect_val(3, 4'h0, 1, "R12 irq_err");
    wr(4'h3, 8'h02);
    wr(4'h1, 8'h65);
    acc(1, 16'h1400);
    acc(1, 16'h0FFF);
    rd(4'h3, 8'h00, "R3 outside window");
    expect_val(1, 4'h0, 1, "R3 busy outside window");
    acc(1, 16'h13FF);
    rd(4'h3, 8'h02, "R3 last window byte");

    // R4 reads
    wr(4'h3, 8'h02);
    wr(4'h1, 8'h65);
    acc(0, 16'h1000);
    rd(4'h3, 8'h00, "R4 awake read");
    nv_sleep = 1'b1;
    acc(0, 16'h1000);
    nv_sleep = 1'b0;
    rd(4'h3, 8'h02, "R4 sleeping read");
    expect_val(1, 4'h0, 0, "R4 busy dropped");

    // R5 disable while busy
    wr(4'h3, 8'h02);
    wr(4'h1, 8'h65);
    wr(4'h1, 8'h00);
    rd(4'h3, 8'h02, "R5 channel disable");
    rd(4'h1, 8'h60, "R5 channel state");
    wr(4'h3, 8'h02);
    wr(4'h1, 8'h65);
    wr(4'h0, 8'h00);
    rd(4'h3, 8'h02, "R5 controller disable");
    expect_val(1, 4'h0, 0, "R5 busy dropped");
    wr(4'h0, 8'h01);

    // R6 channel reset
    wr(4'h1, 8'h01);
    wr(4'h1, 8'h03);
    rd(4'h1, 8'h01, "R6 reset ignored");
    rd(4'h3, 8'h02, "R6 flags kept");
    wr(4'h1, 8'h00);
    wr(4'h1, 8'h02);
    rd(4'h3, 8'h00, "R6 flags cleared");
    rd(4'h2, 8'h00, "R6 trig cleared");
    rd(4'h4, 8'h00, "R6 level cleared");
    rd(4'h5, 8'h00, "R6 scr0 cleared");

    // R7 controller reset
    wr(4'h2, 8'h33);
    wr(4'h0, 8'h03);
    rd(4'h0, 8'h01, "R7 reset ignored");
    rd(4'h2, 8'h33, "R7 trig kept");
    wr(4'h0, 8'h00);
    wr(4'h0, 8'h02);
    rd(4'h2, 8'h00, "R7 trig cleared");

    // R2 no start with controller off
    wr(4'h1, 8'h05);
    expect_val(5, 4'h0, 0, "R2 no start");
    expect_val(1, 4'h0, 0, "R2 stays idle");

    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule